// File: doc/BRIEF.md
# Prioritized CPU Address Translator

This block turns each 16-bit processor address, together with its write flag, into a target code and an 18-bit physical RAM address. The target says which resource answers the access: the processor's own port, the memory-management register window, the I/O space, one of three program ROM sources, the character ROM, or RAM. The mapping inputs come from a separate register file. They are the 8-bit configuration word, the 8-bit shared-RAM word, and two page pointers. Each page pointer has an 8-bit page number and a 4-bit bank field.

Several rules can claim the same address, and a fixed priority order picks the one that applies. From highest to lowest:

1. the processor port cells;
2. the register window;
3. zero-page relocation;
4. stack-page relocation;
5. the shared-RAM area;
6. the per-region ROM/RAM selection made by the configuration word.

A write that would reach a ROM goes to RAM in the selected bank instead. The decode logic is purely combinational. Its result is registered once, so outputs follow inputs by one clock.

Top module: `amap_translate`

## Requirements
- R1: The outputs are registered. On the clock edge that samples an input set, they take that set's result, and they keep their value until the next edge. While `rst_n` is low, `map_tgt` and `map_phys` are 0.
- R2: Target codes are as follows.

  | Code | Target |
  |---|---|
  | 0 | processor port |
  | 1 | register window |
  | 2 | I/O |
  | 3 | system ROM |
  | 4 | internal function ROM |
  | 5 | external function ROM |
  | 6 | character ROM |
  | 7 | RAM |

  Addresses 0x0000 and 0x0001 give code 0 under every setting. For every target other than RAM, `map_phys` is the address zero-extended to 18 bits.
- R3: Addresses 0xFF00 to 0xFF04 give code 1 under every setting. Address 0xFF05 is decoded by the rules below.
- R4: Addresses 0x0002 to 0x00FF give RAM at {`zp_bank`[1:0], `zp_page`, addr[7:0]}. This applies to reads and writes, and it applies even inside the shared area.
- R5: Addresses 0x0100 to 0x01FF give RAM at {`sp_bank`[1:0], `sp_page`, addr[7:0]}. This applies even inside the shared area.
- R6: The shared area is set by the shared-RAM word.
  - Bit 2 places a block at the bottom, from 0x0000 upward. Bit 3 places a block at the top, ending at 0xFFFF.
  - Bits 1-0 give the size of each block: 00 = 1 KB, 01 = 4 KB, 10 = 8 KB, 11 = 16 KB.
  - When both blocks are enabled, each one has the full size.
  - A hit gives RAM at {2'b00, addr}.
- R7: Ordinary RAM accesses go to {1'b0, `cfg_cr`[6], addr}. Configuration bit 7 has no effect.
- R8: Addresses 0x0000 to 0x3FFF are always RAM. For 0x4000 to 0x7FFF, configuration bit 1 selects system ROM (0) or RAM (1).
- R9: Configuration bits 3-2 control 0x8000 to 0xBFFF. Configuration bits 5-4 control 0xC000 to 0xCFFF and 0xE000 to 0xFFFF. In both fields: 00 = system ROM, 01 = internal function ROM, 10 = external function ROM, 11 = RAM.
- R10: For 0xD000 to 0xDFFF, configuration bit 0 = 0 gives I/O. Configuration bit 0 = 1 applies the bits 5-4 coding, except that 00 gives character ROM.
- R11: Configuration bit 0 has no effect on 0xE000 to 0xFFFF.
- R12: A write whose read would reach any ROM (codes 3 to 6) reaches RAM under the R7 address instead. Writes to the processor port, the register window or I/O keep their target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_we | input | 1 | 1 = write access |
| cfg_cr | input | 8 | Configuration word (bank, region selects) |
| cfg_rcr | input | 8 | Shared-RAM word (placement, size) |
| zp_page | input | 8 | Zero-page pointer page number |
| zp_bank | input | 4 | Zero-page pointer bank field |
| sp_page | input | 8 | Stack-page pointer page number |
| sp_bank | input | 4 | Stack-page pointer bank field |
| map_tgt | output | 3 | Target code |
| map_phys | output | 18 | Physical RAM address |

## Verification
The bench checks both edges of every shared-area size, including the 1 KB and 16 KB limits. A design with an off-by-one size would hand an address such as 0x0400 or 0xFBFF to bank 0 instead of the ROM or bank that the configuration selects. It also checks the priority overlaps: zero-page and stack addresses inside an enabled shared area, the register window inside a top shared block, and 0xFF05 just past that window. A design with the order wrong would return bank-0 RAM where a relocated page or a register was due. The 0xD000 page is tested under each configuration bit 0 and bits 5-4 combination, while 0xE000 to 0xFFFF is tested with bit 0 set. Writes are tested to every ROM kind and to I/O, so a design that redirects too much or too little shows up.

// File: rtl/amap_pkg.sv
package amap_pkg;
    localparam int CPU_AW     = 16;
    localparam int PHYS_AW    = 18;
    localparam int PTR_BANK_W = PHYS_AW - CPU_AW;

    typedef enum logic [2:0] {
        TGT_PORT  = 3'd0,
        TGT_MMU   = 3'd1,
        TGT_IO    = 3'd2,
        TGT_SYS   = 3'd3,
        TGT_IFROM = 3'd4,
        TGT_EFROM = 3'd5,
        TGT_CHAR  = 3'd6,
        TGT_RAM   = 3'd7
    } tgt_e;

    typedef struct packed {
        tgt_e               tgt;
        logic [PHYS_AW-1:0] phys;
    } map_res_t;

    function automatic tgt_e decode_sel(input logic [1:0] sel, input tgt_e rom00);
        case (sel)
            2'b00:   return rom00;
            2'b01:   return TGT_IFROM;
            2'b10:   return TGT_EFROM;
            default: return TGT_RAM;
        endcase
    endfunction

    function automatic logic is_rom(input tgt_e t);
        return (t == TGT_SYS) || (t == TGT_IFROM) || (t == TGT_EFROM) || (t == TGT_CHAR);
    endfunction
endpackage

// File: rtl/amap_page_reloc.sv
module amap_page_reloc
    import amap_pkg::*;
#(
    parameter int PAGE = 0
) (
    input  logic [CPU_AW-1:0]  addr,
    input  logic [7:0]         ptr_page,
    input  logic [3:0]         ptr_bank,
    output logic               hit,
    output logic [PHYS_AW-1:0] phys
);
    always_comb begin
        hit  = (addr[CPU_AW-1:8] == 8'(PAGE));
        phys = {ptr_bank[PTR_BANK_W-1:0], ptr_page, addr[7:0]};
    end
endmodule

// File: rtl/amap_shared_area.sv
module amap_shared_area
    import amap_pkg::*;
#(
    parameter int BASE_SHIFT = 10
) (
    input  logic [CPU_AW-1:0] addr,
    input  logic [7:0]        rcr,
    output logic              hit
);
    localparam int EXT_W = CPU_AW + 1;
    localparam logic [EXT_W-1:0] SPAN = EXT_W'(1) << CPU_AW;

    logic [EXT_W-1:0] limit;
    logic [EXT_W-1:0] addr_x;
    logic [1:0]       part_hit;

    always_comb begin
        case (rcr[1:0])
            2'b00:   limit = EXT_W'(1) << BASE_SHIFT;
            2'b01:   limit = EXT_W'(1) << (BASE_SHIFT + 2);
            2'b10:   limit = EXT_W'(1) << (BASE_SHIFT + 3);
            default: limit = EXT_W'(1) << (BASE_SHIFT + 4);
        endcase
        addr_x = {1'b0, addr};
    end

    // part 0 = bottom block (rcr bit 2), part 1 = top block (rcr bit 3)
    for (genvar g = 0; g < 2; g++) begin : g_part
        if (g == 0) begin : g_bottom
            assign part_hit[g] = rcr[2] && (addr_x < limit);
        end else begin : g_top
            assign part_hit[g] = rcr[3] && (addr_x >= (SPAN - limit));
        end
    end

    assign hit = |part_hit;
endmodule

// File: rtl/amap_region_map.sv
module amap_region_map
    import amap_pkg::*;
(
    input  logic [CPU_AW-1:0]  addr,
    input  logic               we,
    input  logic [7:0]         cr,
    output tgt_e               tgt,
    output logic [PHYS_AW-1:0] phys
);
    tgt_e raw;

    always_comb begin
        case (addr[15:14])
            2'b00: raw = TGT_RAM;
            2'b01: raw = cr[1] ? TGT_RAM : TGT_SYS;
            2'b10: raw = decode_sel(cr[3:2], TGT_SYS);
            default: begin
                if (addr[13:12] == 2'b01)
                    raw = cr[0] ? decode_sel(cr[5:4], TGT_CHAR) : TGT_IO;
                else
                    raw = decode_sel(cr[5:4], TGT_SYS);
            end
        endcase
        tgt = (we && is_rom(raw)) ? TGT_RAM : raw;
        if (tgt == TGT_RAM)
            phys = {{(PTR_BANK_W-1){1'b0}}, cr[6], addr};
        else
            phys = {{PTR_BANK_W{1'b0}}, addr};
    end
endmodule

// File: rtl/amap_translate.sv
module amap_translate
    import amap_pkg::*;
#(
    parameter logic [15:0] WIN_BASE  = 16'hFF00,
    parameter int          WIN_COUNT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_we,
    input  logic [7:0]         cfg_cr,
    input  logic [7:0]         cfg_rcr,
    input  logic [7:0]         zp_page,
    input  logic [3:0]         zp_bank,
    input  logic [7:0]         sp_page,
    input  logic [3:0]         sp_bank,
    output logic [2:0]         map_tgt,
    output logic [17:0]        map_phys
);
    localparam logic [16:0] WIN_END = {1'b0, WIN_BASE} + 17'(WIN_COUNT);

    tgt_e               reg_tgt;
    logic [PHYS_AW-1:0] reg_phys;
    logic               shared_hit;
    logic [7:0]         ptr_page [2];
    logic [3:0]         ptr_bank [2];
    logic [1:0]         rel_hit;
    logic [PHYS_AW-1:0] rel_phys [2];
    map_res_t           res_d, res_q;

    assign ptr_page[0] = zp_page;
    assign ptr_bank[0] = zp_bank;
    assign ptr_page[1] = sp_page;
    assign ptr_bank[1] = sp_bank;

    amap_region_map u_region (
        .addr (cpu_addr),
        .we   (cpu_we),
        .cr   (cfg_cr),
        .tgt  (reg_tgt),
        .phys (reg_phys)
    );

    amap_shared_area u_shared (
        .addr (cpu_addr),
        .rcr  (cfg_rcr),
        .hit  (shared_hit)
    );

    for (genvar p = 0; p < 2; p++) begin : g_reloc
        amap_page_reloc #(.PAGE(p)) u_reloc (
            .addr     (cpu_addr),
            .ptr_page (ptr_page[p]),
            .ptr_bank (ptr_bank[p]),
            .hit      (rel_hit[p]),
            .phys     (rel_phys[p])
        );
    end

    // later assignments win: lowest priority first
    always_comb begin
        res_d.tgt  = reg_tgt;
        res_d.phys = reg_phys;
        if (shared_hit) begin
            res_d.tgt  = TGT_RAM;
            res_d.phys = {{PTR_BANK_W{1'b0}}, cpu_addr};
        end
        if (rel_hit[1]) begin
            res_d.tgt  = TGT_RAM;
            res_d.phys = rel_phys[1];
        end
        if (rel_hit[0]) begin
            res_d.tgt  = TGT_RAM;
            res_d.phys = rel_phys[0];
        end
        if (({1'b0, cpu_addr} >= {1'b0, WIN_BASE}) && ({1'b0, cpu_addr} < WIN_END)) begin
            res_d.tgt  = TGT_MMU;
            res_d.phys = {{PTR_BANK_W{1'b0}}, cpu_addr};
        end
        if (cpu_addr[15:1] == 15'd0) begin
            res_d.tgt  = TGT_PORT;
            res_d.phys = {{PTR_BANK_W{1'b0}}, cpu_addr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '{tgt: TGT_PORT, phys: '0};
        else        res_q <= res_d;
    end

    assign map_tgt  = res_q.tgt;
    assign map_phys = res_q.phys;
endmodule

// File: rtl/amap_checker.sv
module amap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_we,
    input logic [7:0]  cfg_rcr,
    input logic [7:0]  zp_page,
    input logic [3:0]  zp_bank,
    input logic [2:0]  map_tgt,
    input logic [17:0] map_phys
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_port_cells_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cpu_addr) <= 16'h0001) |->
        (map_tgt == 3'd0 && map_phys == {2'b00, $past(cpu_addr)}));

    p_reg_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cpu_addr) >= 16'hFF00 && $past(cpu_addr) <= 16'hFF04) |->
        (map_tgt == 3'd1));

    p_zero_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cpu_addr[15:8]) == 8'h00 && $past(cpu_addr[7:1]) != 7'd0) |->
        (map_tgt == 3'd7 &&
         map_phys == {$past(zp_bank[1:0]), $past(zp_page), $past(cpu_addr[7:0])}));

    p_shared_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cfg_rcr[2]) && $past(cpu_addr) >= 16'h0200 &&
         $past(cpu_addr) < 16'h0400) |->
        (map_tgt == 3'd7 && map_phys[17:16] == 2'b00));

    p_no_rom_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cpu_we)) |-> !(map_tgt >= 3'd3 && map_tgt <= 3'd6));
endmodule

bind amap_translate amap_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .cfg_rcr  (cfg_rcr),
    .zp_page  (zp_page),
    .zp_bank  (zp_bank),
    .map_tgt  (map_tgt),
    .map_phys (map_phys)
);

// File: tb/amap_translate_tb.sv
module amap_translate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cfg_cr = '0;
    logic [7:0]  cfg_rcr = '0;
    logic [7:0]  zp_page = 8'h42;
    logic [3:0]  zp_bank = 4'h1;
    logic [7:0]  sp_page = 8'h37;
    logic [3:0]  sp_bank = 4'h2;
    logic [2:0]  map_tgt;
    logic [17:0] map_phys;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    amap_translate u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cfg_cr(cfg_cr), .cfg_rcr(cfg_rcr), .zp_page(zp_page), .zp_bank(zp_bank),
        .sp_page(sp_page), .sp_bank(sp_bank), .map_tgt(map_tgt), .map_phys(map_phys)
    );

    // {req, addr, we, cr, rcr, exp_tgt, exp_phys}
    localparam int NV = 45;
    localparam logic [57:0] VEC [NV] = '{
        {4'd2,  16'h0000,1'b0,8'h00,8'h00,3'd0,18'h00000},  // R2
        {4'd2,  16'h0001,1'b1,8'h3F,8'h0C,3'd0,18'h00001},  // R2
        {4'd3,  16'hFF00,1'b0,8'h3F,8'h00,3'd1,18'h0FF00},  // R3
        {4'd3,  16'hFF04,1'b1,8'hFF,8'h0F,3'd1,18'h0FF04},  // R3 over top block
        {4'd3,  16'hFF05,1'b0,8'h3F,8'h00,3'd7,18'h0FF05},  // R3 end of window
        {4'd4,  16'h0002,1'b0,8'h00,8'h0C,3'd7,18'h14202},  // R4
        {4'd4,  16'h00FF,1'b1,8'h7F,8'h00,3'd7,18'h142FF},  // R4
        {4'd5,  16'h0100,1'b0,8'h00,8'h0F,3'd7,18'h23700},  // R5
        {4'd5,  16'h01FF,1'b0,8'h40,8'h00,3'd7,18'h237FF},  // R5
        {4'd6,  16'h0200,1'b0,8'h40,8'h04,3'd7,18'h00200},  // R6 1KB bottom
        {4'd6,  16'h0400,1'b0,8'h40,8'h04,3'd7,18'h10400},  // R6 past 1KB
        {4'd6,  16'h0FFF,1'b0,8'h40,8'h05,3'd7,18'h00FFF},  // R6 4KB
        {4'd6,  16'h1000,1'b0,8'h40,8'h05,3'd7,18'h11000},  // R6 past 4KB
        {4'd6,  16'h1FFF,1'b0,8'h40,8'h06,3'd7,18'h01FFF},  // R6 8KB
        {4'd6,  16'h3FFF,1'b0,8'h40,8'h07,3'd7,18'h03FFF},  // R6 16KB
        {4'd6,  16'h4000,1'b0,8'h40,8'h07,3'd3,18'h04000},  // R6 past 16KB
        {4'd6,  16'hFC00,1'b0,8'h40,8'h08,3'd7,18'h0FC00},  // R6 top 1KB
        {4'd6,  16'hFBFF,1'b0,8'h40,8'h08,3'd3,18'h0FBFF},  // R6 below top
        {4'd6,  16'hC000,1'b0,8'h40,8'h0F,3'd7,18'h0C000},  // R6 both 16KB top
        {4'd6,  16'h3FFF,1'b0,8'h40,8'h0F,3'd7,18'h03FFF},  // R6 both bottom
        {4'd6,  16'h8000,1'b0,8'h40,8'h0E,3'd3,18'h08000},  // R6 both 8KB gap
        {4'd8,  16'h4000,1'b0,8'h02,8'h00,3'd7,18'h04000},  // R8
        {4'd8,  16'h4000,1'b0,8'h42,8'h00,3'd7,18'h14000},  // R8
        {4'd9,  16'h8000,1'b0,8'h04,8'h00,3'd4,18'h08000},  // R9
        {4'd9,  16'hBFFF,1'b0,8'h08,8'h00,3'd5,18'h0BFFF},  // R9
        {4'd9,  16'h9000,1'b0,8'h0C,8'h00,3'd7,18'h09000},  // R9
        {4'd9,  16'hC000,1'b0,8'h10,8'h00,3'd4,18'h0C000},  // R9
        {4'd9,  16'hCFFF,1'b0,8'h20,8'h00,3'd5,18'h0CFFF},  // R9
        {4'd9,  16'hE000,1'b0,8'h30,8'h00,3'd7,18'h0E000},  // R9
        {4'd7,  16'h0400,1'b0,8'h80,8'h00,3'd7,18'h00400},  // R7 bit7 ignored
        {4'd7,  16'h0400,1'b0,8'hC0,8'h00,3'd7,18'h10400},  // R7
        {4'd10, 16'hD000,1'b0,8'h30,8'h00,3'd2,18'h0D000},  // R10
        {4'd12, 16'hDFFF,1'b1,8'h00,8'h00,3'd2,18'h0DFFF},  // R12 I/O write
        {4'd10, 16'hD000,1'b0,8'h01,8'h00,3'd6,18'h0D000},  // R10
        {4'd10, 16'hD800,1'b0,8'h11,8'h00,3'd4,18'h0D800},  // R10
        {4'd10, 16'hDABC,1'b0,8'h21,8'h00,3'd5,18'h0DABC},  // R10
        {4'd10, 16'hDFFF,1'b0,8'h31,8'h00,3'd7,18'h0DFFF},  // R10
        {4'd11, 16'hE000,1'b0,8'h01,8'h00,3'd3,18'h0E000},  // R11
        {4'd11, 16'hFFFF,1'b0,8'h11,8'h00,3'd4,18'h0FFFF},  // R11
        {4'd11, 16'hFEFF,1'b0,8'h21,8'h00,3'd5,18'h0FEFF},  // R11
        {4'd12, 16'h4000,1'b1,8'h40,8'h00,3'd7,18'h14000},  // R12
        {4'd12, 16'hD000,1'b1,8'h41,8'h00,3'd7,18'h1D000},  // R12 char ROM
        {4'd12, 16'hE123,1'b1,8'h50,8'h00,3'd7,18'h1E123},  // R12
        {4'd12, 16'h8000,1'b1,8'h48,8'h00,3'd7,18'h18000},  // R12
        {4'd4,  16'h0050,1'b1,8'h01,8'h0F,3'd7,18'h14250}   // R4 over shared
    };

    task automatic check(input string req, input logic [2:0] et, input logic [17:0] ep);
        n_checks++;
        if (map_tgt !== et || map_phys !== ep) begin
            n_errors++;
            $display("FAIL %s: tgt=%0d phys=%05h expected tgt=%0d phys=%05h",
                     req, map_tgt, map_phys, et, ep);
        end
    endtask

    initial begin
        // R1 reset state
        #5;
        check("R1", 3'd0, 18'h0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cpu_addr, cpu_we, cfg_cr, cfg_rcr} = VEC[i][56:21];
            @(negedge clk);
            check($sformatf("R%0d", VEC[i][57:54]), VEC[i][20:18], VEC[i][17:0]);
        end
        // R1: output holds until the next edge
        @(negedge clk);
        cpu_addr = 16'h0400; cpu_we = 1'b0; cfg_cr = 8'h40; cfg_rcr = 8'h00;
        @(negedge clk);
        check("R1", 3'd7, 18'h10400);
        cpu_addr = 16'hFF01;
        #5;
        check("R1", 3'd7, 18'h10400);
        @(negedge clk);
        check("R3", 3'd1, 18'h0FF01);
        // R5 stack pointer change, upper bank bits dropped
        sp_page = 8'hA5; sp_bank = 4'hF; cpu_addr = 16'h0133;
        @(negedge clk);
        check("R5", 3'd7, 18'h3A533);
        // R1 reset mid-run
        rst_n = 1'b0;
        #2;
        check("R1", 3'd0, 18'h0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule